// File: doc/BRIEF.md
# PCI Configuration Access Port

This block is the host-side end of an indirect configuration mechanism. A processor-side request port presents a window offset, an access size of 1, 2 or 4 bytes, write data and a read/write flag. The lower part of the window holds a 32-bit configuration address register. Accesses to the upper part are configuration data cycles. Each one is steered by the fields of that register: to the bridge's own 256-byte configuration space, or to a downstream device bus that carries device, function, register, size and data.

The stored address register keeps the byte-swapped layout a little-endian host produces. The enable flag therefore sits at bit 7, and the register number sits in the top byte. The local space holds its bytes in big-endian order. A control bit in that space asks for memory setup: every local write that leaves the bit set sends out a one-cycle start pulse.

Each request is accepted in the cycle it is presented. It produces a response exactly two clock edges later. An error pulse accompanies that response when the access was rejected.

Top module: `cfg_access_port`

## Requirements
- R1: A write at a window offset below 0x200000 loads the whole 32-bit address register from the write data, whatever the size. A read at such an offset returns 0 with no error.
- R2: A data access (offset at or above 0x200000) takes effect only if bit 7 of the address register is 1. Otherwise a read returns 0, a write changes nothing, and no error is flagged.
- R3: The address register fields are: bus at bits 15:8, device at bits 23:19, function at bits 18:16, and register number at bits 31:24 with bits 25:24 forced to zero.
- R4: An enabled access with a nonzero bus field is rejected. A read returns 0, a write changes nothing, and the error pulse is raised.
- R5: Device 0 with function 0 selects the local space. Any other device/function pair whose device bit is set in `ds_present` is sent out as a one-cycle `ds_valid` carrying the device, function, register, size and write data. A forwarded read returns `ds_rdata`.
- R6: An enabled access to a device whose `ds_present` bit is clear produces no `ds_valid`. A read returns 0, and the error pulse is raised.
- R7: The local space is big-endian. A 1-byte write stores data bits 7:0 at the register offset. A 2-byte write stores bits 15:8 at the offset and bits 7:0 at offset+1. A 4-byte write stores bits 31:24 at the offset, down to bits 7:0 at offset+3. Reads return the bytes right-aligned in the same order.
- R8: `mem_setup_start` pulses for one cycle, together with the response of a local write, when bit 3 of local byte 0xF2 is 1 after that write.
- R9: An enabled data access with a size other than 1, 2 or 4 raises the error pulse. A read returns 0 and a write changes nothing.
- R10: After reset the address register is 0, so data access is disabled, and every byte of the local space reads 0.
- R11: Every request produces `rsp_valid` exactly two clock edges after it is sampled. `err_pulse` is only ever high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 22 | Offset inside the register window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the request two edges earlier |
| rsp_rdata | output | 32 | Read data, right-aligned |
| err_pulse | output | 1 | Rejected access, valid with rsp_valid |
| mem_setup_start | output | 1 | One-cycle memory setup trigger |
| ds_valid | output | 1 | Forwarded downstream access |
| ds_write | output | 1 | Downstream access is a write |
| ds_dev | output | 5 | Downstream device number |
| ds_func | output | 3 | Downstream function number |
| ds_reg | output | 8 | Downstream register offset |
| ds_size | output | 3 | Downstream access size |
| ds_wdata | output | 32 | Downstream write data |
| ds_present | input | 32 | One bit per downstream device that exists |
| ds_rdata | input | 32 | Downstream read data, sampled the cycle after ds_valid |

## Verification
The pipeline can hold a data access and a reload of the address register at the same time. A data access presented just before an address write must still be steered by the old register value. An access presented just after the write must use the new one. The bench provokes this with back-to-back requests: a local read, then an address write that moves the register number, then another read. It judges the outcome by comparing each response against the bytes at the register offset that was in force when that request was sampled. The memory setup pulse and the response of the write that caused it also share a cycle. That pairing is checked on the same sampling edge.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    RT_ZERO   = 2'd0,
    RT_LOCAL  = 2'd1,
    RT_REMOTE = 2'd2
  } rd_route_t;

  typedef struct packed {
    logic [7:0] reg_ofs;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [7:0] bus;
    logic       en;
  } cfg_fields_t;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgp_pkg::*;
(
  input  logic [31:0] addr_word,
  output cfg_fields_t fields
);
  // Byte-swapped layout: enable in bit 7, register number in the top byte.
  always_comb begin
    fields.en      = addr_word[7];
    fields.bus     = addr_word[15:8];
    fields.fn      = addr_word[18:16];
    fields.dev     = addr_word[23:19];
    fields.reg_ofs = {addr_word[31:26], 2'b00};
  end
endmodule

// File: rtl/cfg_local_space.sv
module cfg_local_space #(
  parameter int          CFG_BYTES = 256,
  parameter logic [7:0]  TRIG_OFS  = 8'hF2,
  localparam int         WORDS     = CFG_BYTES / 4,
  localparam int         IDX_W     = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_size,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_lanes,
  output logic [7:0]       trig_byte
);
  localparam int TRIG_LANE = int'(TRIG_OFS[1:0]);
  localparam int TRIG_IDX  = int'(TRIG_OFS) / 4;

  // Four byte lanes; lane k holds the byte at word*4+k.
  // rd_lanes carries lane 0 in bits 31:24 (big-endian order).
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic       lane_en;
    logic [7:0] lane_byte;
    logic [7:0] rd_q;

    always_comb begin
      lane_en   = 1'b0;
      lane_byte = 8'h00;
      case (wr_size)
        3'd1: begin
          lane_en   = (k == 0);
          lane_byte = wdata[7:0];
        end
        3'd2: begin
          lane_en   = (k < 2);
          lane_byte = (k == 0) ? wdata[15:8] : wdata[7:0];
        end
        3'd4: begin
          lane_en   = 1'b1;
          lane_byte = wdata[8*(3-k) +: 8];
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
        rd_q <= 8'h00;
      end else begin
        if (wr_en && lane_en) mem[wr_idx] <= lane_byte;
        rd_q <= mem[rd_idx];
      end
    end

    assign rd_lanes[8*(3-k) +: 8] = rd_q;

    if (k == TRIG_LANE) begin : g_trig
      assign trig_byte = mem[TRIG_IDX];
    end
  end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter int          OFS_W     = 22,
  parameter logic [31:0] DATA_BASE = 32'h0020_0000,
  parameter int          CFG_BYTES = 256,
  parameter int          NUM_DEV   = 32,
  parameter logic [7:0]  TRIG_OFS  = 8'hF2,
  parameter int          TRIG_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             err_pulse,
  output logic             mem_setup_start,
  output logic             ds_valid,
  output logic             ds_write,
  output logic [4:0]       ds_dev,
  output logic [2:0]       ds_func,
  output logic [7:0]       ds_reg,
  output logic [2:0]       ds_size,
  output logic [31:0]      ds_wdata,
  input  logic [NUM_DEV-1:0] ds_present,
  input  logic [31:0]      ds_rdata
);
  localparam int         WORDS   = CFG_BYTES / 4;
  localparam int         IDX_W   = $clog2(WORDS);
  localparam logic [OFS_W-1:0] DATA_LIM = DATA_BASE[OFS_W-1:0];

  // ---------------- address register ----------------
  logic [31:0] addr_q;
  cfg_fields_t fld;

  cfg_addr_decode u_dec (
    .addr_word (addr_q),
    .fields    (fld)
  );

  // ---------------- request classification ----------------
  logic is_data, addr_wr, live, bus_bad, size_bad;
  logic local_hit, dev_here;
  logic do_local_wr, do_local_rd, do_fwd, rej;

  always_comb begin
    is_data   = (req_offset >= DATA_LIM);
    addr_wr   = req_valid && req_write && !is_data;
    live      = req_valid && is_data && fld.en;
    bus_bad   = live && (fld.bus != 8'h00);
    size_bad  = live && !bus_bad && !size_legal(req_size);
    local_hit = (fld.dev == 5'd0) && (fld.fn == 3'd0);
    dev_here  = ds_present[fld.dev];
    do_local_wr = live && !bus_bad && !size_bad && local_hit && req_write;
    do_local_rd = live && !bus_bad && !size_bad && local_hit && !req_write;
    do_fwd      = live && !bus_bad && !size_bad && !local_hit && dev_here;
    rej         = bus_bad || size_bad || (live && !local_hit && !dev_here);
  end

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= 32'h0;
    else if (addr_wr) addr_q <= req_wdata;
  end

  // ---------------- local configuration space ----------------
  logic [31:0] lane_q;
  logic [7:0]  trig_byte;

  cfg_local_space #(
    .CFG_BYTES (CFG_BYTES),
    .TRIG_OFS  (TRIG_OFS)
  ) u_space (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (do_local_wr),
    .wr_size   (req_size),
    .wr_idx    (fld.reg_ofs[IDX_W+1:2]),
    .wdata     (req_wdata),
    .rd_idx    (fld.reg_ofs[IDX_W+1:2]),
    .rd_lanes  (lane_q),
    .trig_byte (trig_byte)
  );

  // ---------------- stage 1 ----------------
  logic      s1_valid, s1_err, s1_local_wr;
  rd_route_t s1_route;
  logic [2:0] s1_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_err      <= 1'b0;
      s1_local_wr <= 1'b0;
      s1_route    <= RT_ZERO;
      s1_size     <= 3'd0;
      ds_valid    <= 1'b0;
      ds_write    <= 1'b0;
      ds_dev      <= 5'd0;
      ds_func     <= 3'd0;
      ds_reg      <= 8'h00;
      ds_size     <= 3'd0;
      ds_wdata    <= 32'h0;
    end else begin
      s1_valid    <= req_valid;
      s1_err      <= rej;
      s1_local_wr <= do_local_wr;
      s1_size     <= req_size;
      if (do_local_rd)                  s1_route <= RT_LOCAL;
      else if (do_fwd && !req_write)    s1_route <= RT_REMOTE;
      else                              s1_route <= RT_ZERO;
      ds_valid <= do_fwd;
      if (do_fwd) begin
        ds_write <= req_write;
        ds_dev   <= fld.dev;
        ds_func  <= fld.fn;
        ds_reg   <= fld.reg_ofs;
        ds_size  <= req_size;
        ds_wdata <= req_wdata;
      end
    end
  end

  // ---------------- stage 2 ----------------
  logic [31:0] local_rd;

  always_comb begin
    case (s1_size)
      3'd1:    local_rd = {24'h0, lane_q[31:24]};
      3'd2:    local_rd = {16'h0, lane_q[31:16]};
      default: local_rd = lane_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_rdata       <= 32'h0;
      err_pulse       <= 1'b0;
      mem_setup_start <= 1'b0;
    end else begin
      rsp_valid       <= s1_valid;
      err_pulse       <= s1_err;
      mem_setup_start <= s1_local_wr && trig_byte[TRIG_BIT];
      case (s1_route)
        RT_LOCAL:  rsp_rdata <= local_rd;
        RT_REMOTE: rsp_rdata <= ds_rdata;
        default:   rsp_rdata <= 32'h0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid);

  assert_err_with_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> rsp_valid);

  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(addr_q[7], 2)) |-> (rsp_rdata == 32'h0));

  assert_fwd_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> ($past(addr_q[7]) && ($past(addr_q[15:8]) == 8'h00)));

  assert_no_self_forward_R5: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> !((ds_dev == 5'd0) && (ds_func == 3'd0)));

  assert_setup_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_setup_start |-> ($past(req_valid, 2) && $past(req_write, 2)));

  assert_reject_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && err_pulse) |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/cfg_access_port_tb.sv
`timescale 1ns/1ps
module cfg_access_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, err_pulse, mem_setup_start;
  logic [31:0] rsp_rdata;
  logic        ds_valid, ds_write;
  logic [4:0]  ds_dev;
  logic [2:0]  ds_func;
  logic [7:0]  ds_reg;
  logic [2:0]  ds_size;
  logic [31:0] ds_wdata;
  logic [31:0] ds_present = 32'h0000_0024;
  logic [31:0] ds_rdata;

  int checks = 0;
  int errors = 0;

  localparam logic [21:0] DWIN = 22'h20_0000;

  always #2 clk = ~clk;

  assign ds_rdata = {ds_dev, ds_func, ds_reg, 16'hC0DE};

  cfg_access_port dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
    .mem_setup_start(mem_setup_start), .ds_valid(ds_valid), .ds_write(ds_write),
    .ds_dev(ds_dev), .ds_func(ds_func), .ds_reg(ds_reg), .ds_size(ds_size),
    .ds_wdata(ds_wdata), .ds_present(ds_present), .ds_rdata(ds_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic en, input logic [7:0] bus,
      input logic [4:0] dev, input logic [2:0] fn, input logic [7:0] rg);
    return {rg, dev, fn, bus, en, 7'b0};
  endfunction

  // Drive at a falling edge; response is visible after the second rising edge.
  task automatic access(input logic wr, input logic [21:0] ofs, input logic [2:0] sz,
      input logic [31:0] wd, output logic [31:0] rd, output logic er,
      output logic su, output logic dv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    dv = ds_valid;
    @(negedge clk);
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    rd = rsp_rdata; er = err_pulse; su = mem_setup_start;
  endtask

  task automatic set_addr(input logic [31:0] a);
    logic [31:0] rd; logic er, su, dv;
    access(1'b1, 22'h000010, 3'd4, a, rd, er, su, dv);
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic er, su, dv;
    chk("R10 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    chk("R10 ds_valid idle", {31'b0, ds_valid}, 32'h0);
    access(1'b0, 22'h000000, 3'd4, 32'h0, rd, er, su, dv);
    chk("R1 addr reg reads zero", rd, 32'h0);
    chk("R1 addr read no error", {31'b0, er}, 32'h0);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R10 disabled after reset", rd, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'hF0));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R10 local space zero", rd, 32'h0);
  endtask

  task automatic t_endian;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b1, DWIN, 3'd4, 32'h1122_3344, rd, er, su, dv);
    chk("R7 4B write no error", {31'b0, er}, 32'h0);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R7 4B readback", rd, 32'h1122_3344);
    access(1'b0, DWIN, 3'd2, 32'h0, rd, er, su, dv);
    chk("R7 2B read", rd, 32'h0000_1122);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h13));
    access(1'b0, DWIN, 3'd1, 32'h0, rd, er, su, dv);
    chk("R3 low offset bits cleared", rd, 32'h0000_0011);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h20));
    access(1'b1, DWIN, 3'd2, 32'h0000_AABB, rd, er, su, dv);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R7 2B write lanes", rd, 32'hAABB_0000);
    access(1'b1, DWIN, 3'd1, 32'h0000_0077, rd, er, su, dv);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R7 1B write lane0", rd, 32'h77BB_0000);
  endtask

  task automatic t_disabled;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b0, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b1, DWIN, 3'd4, 32'hDEAD_0000, rd, er, su, dv);
    chk("R2 disabled write no error", {31'b0, er}, 32'h0);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R2 disabled read zero", rd, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R2 disabled write dropped", rd, 32'h1122_3344);
  endtask

  task automatic t_bus;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b1, 8'h01, 5'd0, 3'd0, 8'h10));
    access(1'b1, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R4 bus write error", {31'b0, er}, 32'h1);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R4 bus read error", {31'b0, er}, 32'h1);
    chk("R4 bus read zero", rd, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R4 bus write no effect", rd, 32'h1122_3344);
  endtask

  task automatic t_downstream;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b1, 8'h00, 5'd5, 3'd3, 8'h41));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R5 fwd read valid", {31'b0, dv}, 32'h1);
    chk("R3 fwd fields", {16'h0, ds_dev, ds_func, ds_reg}, {16'h0, 5'd5, 3'd3, 8'h40});
    chk("R5 fwd read data", rd, 32'h2B40_C0DE);
    chk("R5 fwd read no error", {31'b0, er}, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd2, 3'd0, 8'h08));
    access(1'b1, DWIN, 3'd2, 32'h0000_1234, rd, er, su, dv);
    chk("R5 fwd write valid", {31'b0, dv}, 32'h1);
    chk("R5 fwd write attrs", {ds_wdata[15:0], 5'b0, ds_write, 7'b0, ds_size},
        {16'h1234, 5'b0, 1'b1, 7'b0, 3'd2});
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd1, 8'h00));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R6 absent no ds_valid", {31'b0, dv}, 32'h0);
    chk("R6 absent error", {31'b0, er}, 32'h1);
    chk("R6 absent read zero", rd, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd7, 3'd0, 8'h00));
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R6 absent dev7 error", {31'b0, er}, 32'h1);
  endtask

  task automatic t_size;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b1, DWIN, 3'd3, 32'hFFFF_FFFF, rd, er, su, dv);
    chk("R9 size3 write error", {31'b0, er}, 32'h1);
    access(1'b0, DWIN, 3'd0, 32'h0, rd, er, su, dv);
    chk("R9 size0 read error", {31'b0, er}, 32'h1);
    chk("R9 size0 read zero", rd, 32'h0);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R9 bad write ignored", rd, 32'h1122_3344);
  endtask

  task automatic t_trigger;
    logic [31:0] rd; logic er, su, dv;
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'hF0));
    access(1'b1, DWIN, 3'd4, 32'h0000_0800, rd, er, su, dv);
    chk("R8 pulse on setting write", {31'b0, su}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, mem_setup_start}, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    access(1'b1, DWIN, 3'd1, 32'h0000_0011, rd, er, su, dv);
    chk("R8 pulse while bit stays set", {31'b0, su}, 32'h1);
    access(1'b0, DWIN, 3'd4, 32'h0, rd, er, su, dv);
    chk("R8 no pulse on read", {31'b0, su}, 32'h0);
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'hF0));
    access(1'b1, DWIN, 3'd4, 32'h0000_F700, rd, er, su, dv);
    chk("R8 no pulse when bit clear", {31'b0, su}, 32'h0);
  endtask

  task automatic t_back_to_back;
    set_addr(mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h10));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = DWIN; req_size = 3'd4;
    @(negedge clk);
    req_write = 1'b1; req_offset = 22'h000004;
    req_wdata = mk_addr(1'b1, 8'h00, 5'd0, 3'd0, 8'h20);
    @(negedge clk);
    req_write = 1'b0; req_offset = DWIN;
    chk("R11 b2b rsp0 valid", {31'b0, rsp_valid}, 32'h1);
    chk("R11 b2b old addr used", rsp_rdata, 32'h1122_3344);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b addr write rsp", {rsp_valid, 31'b0} | rsp_rdata, 32'h8000_0000);
    @(negedge clk);
    chk("R11 b2b rsp2 valid", {31'b0, rsp_valid}, 32'h1);
    chk("R1 b2b new addr used", rsp_rdata, 32'h77BB_0000);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_endian();
    t_disabled();
    t_bus();
    t_downstream();
    t_size();
    t_trigger();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule